// File: doc/BRIEF.md
# Iterative Integer Multiply/Divide Unit

This block computes a 32-bit integer product or quotient/remainder one bit per clock, sharing one adder and one pair of shift registers between the two operations. A caller pulses `start_i` with an opcode and two operands. The unit raises `busy_o` for the full run and then pulses `done_o` for one cycle. The two 32-bit result registers `hi_o` and `lo_o` can be read at any time.

Multiplication forms the full 64-bit product. The upper half goes to `hi_o` and the lower half to `lo_o`. Division is restoring: each step subtracts the divisor and keeps the result only when it is not negative. The remainder goes to `hi_o` and the quotient to `lo_o`.

Signed operations work on magnitudes, then a single extra cycle applies the signs. A zero divisor raises no trap. The run still completes, and the result it leaves is fixed by the datapath.

Top module: `muldiv_seq`

## Requirements
- R1: While reset is asserted and after its release, `busy_o` and `done_o` are 0 and `hi_o` and `lo_o` are all zeros.
- R2: A `start_i` pulse while `busy_o` is low starts an operation. `busy_o` is high from the next cycle for exactly WIDTH+1 cycles. `done_o` is high for the single cycle after `busy_o` falls.
- R3: Opcode 2'b00 (unsigned multiply) leaves `{hi_o, lo_o}` equal to the 64-bit unsigned product of `a_i` and `b_i`.
- R4: Opcode 2'b01 (signed multiply) leaves `{hi_o, lo_o}` equal to the 64-bit two's-complement product. This includes operands at the most negative value.
- R5: Opcode 2'b10 (unsigned divide, nonzero divisor) leaves the remainder in `hi_o` and the quotient in `lo_o`.
- R6: Opcode 2'b11 (signed divide, nonzero divisor) produces a quotient that truncates toward zero and is negated when the operand signs differ. The remainder carries the sign of the dividend. 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R7: A zero divisor takes the same number of cycles and always leaves `hi_o` equal to the dividend. For unsigned divide, `lo_o` is 0xFFFFFFFF. For signed divide, `lo_o` is 0xFFFFFFFF if the dividend is non-negative and 0x00000001 if it is negative.
- R8: A `start_i` pulse while `busy_o` is high is ignored. The running operation completes on its original operands and timing.
- R9: `hi_o` and `lo_o` change only in the cycle where `done_o` is high, and otherwise hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| op_i | input | 2 | Bit 1 selects divide, bit 0 selects signed |
| a_i | input | WIDTH | Multiplicand or dividend |
| b_i | input | WIDTH | Multiplier or divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | WIDTH | Product upper half or remainder |
| lo_o | output | WIDTH | Product lower half or quotient |

## Verification
The bench builds the unit with the default WIDTH of 32, which is also the width its behavioural model assumes. At that width, the step counter runs through its full five-bit range on every operation. The most negative operand, 0x80000000, can be driven directly, so the magnitude and sign-fix corner cases (minimum value times itself, minimum value divided by minus one, zero divisor of either sign) are exercised as directed cases. Those directed cases are followed by random operations and by start pulses injected mid-run.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  // opcode bit positions
  localparam int OPB_SIGNED = 0;
  localparam int OPB_DIV    = 1;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FIX  = 2'b10
  } md_state_e;
endpackage

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
  import muldiv_pkg::*;
#(
  parameter int STEPS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic fix_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;

  md_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic done_q, done_d;
  logic last_step;

  assign last_step = (cnt_q == CW'(STEPS - 1));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (last_step) state_d = ST_FIX;
      end
      ST_FIX: begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_RUN);
  assign fix_o  = (state_q == ST_FIX);
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/muldiv_datapath.sv
module muldiv_datapath
  import muldiv_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic             step_en,
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] raw_hi_o,
  output logic [WIDTH-1:0] raw_lo_o,
  output logic             is_div_o,
  output logic             neg_quo_o,
  output logic             neg_rem_o
);
  localparam int AW = WIDTH + 2;

  logic [WIDTH-1:0] acc_q, acc_d;
  logic [WIDTH-1:0] rq_q, rq_d;
  logic [WIDTH-1:0] m_q;
  logic             div_q, nq_q, nr_q;

  logic             a_neg, b_neg;
  logic [WIDTH-1:0] a_mag, b_mag;

  logic [WIDTH:0]   shifted;
  logic [AW-1:0]    add_x, add_y, add_s;
  logic             add_sub, rem_neg;

  // operand magnitudes at load
  assign a_neg = op_i[OPB_SIGNED] & a_i[WIDTH-1];
  assign b_neg = op_i[OPB_SIGNED] & b_i[WIDTH-1];
  assign a_mag = a_neg ? -a_i : a_i;
  assign b_mag = b_neg ? -b_i : b_i;

  // shared adder: multiply adds, divide subtracts
  assign shifted = {acc_q, rq_q[WIDTH-1]};
  assign add_sub = div_q;
  assign add_x   = div_q ? {1'b0, shifted} : {2'b00, acc_q};
  assign add_y   = (div_q || rq_q[0]) ? {2'b00, m_q} : '0;
  assign add_s   = add_x + (add_sub ? ~add_y : add_y) + {{(AW-1){1'b0}}, add_sub};
  assign rem_neg = add_s[AW-1];

  always_comb begin
    if (div_q) begin
      acc_d = rem_neg ? shifted[WIDTH-1:0] : add_s[WIDTH-1:0];
      rq_d  = {rq_q[WIDTH-2:0], ~rem_neg};
    end else begin
      acc_d = add_s[WIDTH:1];
      rq_d  = {add_s[0], rq_q[WIDTH-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      rq_q  <= '0;
      m_q   <= '0;
      div_q <= 1'b0;
      nq_q  <= 1'b0;
      nr_q  <= 1'b0;
    end else if (load_en) begin
      acc_q <= '0;
      rq_q  <= a_mag;
      m_q   <= b_mag;
      div_q <= op_i[OPB_DIV];
      nq_q  <= a_neg ^ b_neg;
      nr_q  <= a_neg;
    end else if (step_en) begin
      acc_q <= acc_d;
      rq_q  <= rq_d;
    end
  end

  assign raw_hi_o  = acc_q;
  assign raw_lo_o  = rq_q;
  assign is_div_o  = div_q;
  assign neg_quo_o = nq_q;
  assign neg_rem_o = nr_q;
endmodule

// File: rtl/muldiv_signfix.sv
module muldiv_signfix #(
  parameter int WIDTH = 32
) (
  input  logic             is_div_i,
  input  logic             neg_quo_i,
  input  logic             neg_rem_i,
  input  logic [WIDTH-1:0] raw_hi_i,
  input  logic [WIDTH-1:0] raw_lo_i,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  localparam int PW = 2 * WIDTH;

  logic [PW-1:0] prod, prod_neg;

  assign prod     = {raw_hi_i, raw_lo_i};
  assign prod_neg = -prod;

  always_comb begin
    if (is_div_i) begin
      hi_o = neg_rem_i ? -raw_hi_i : raw_hi_i;
      lo_o = neg_quo_i ? -raw_lo_i : raw_lo_i;
    end else begin
      {hi_o, lo_o} = neg_quo_i ? prod_neg : prod;
    end
  end
endmodule

// File: rtl/muldiv_seq.sv
module muldiv_seq #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [WIDTH-1:0] hi_o,
  output logic [WIDTH-1:0] lo_o
);
  logic load_en, step_en, fix_en;
  logic [WIDTH-1:0] raw_hi, raw_lo, fix_hi, fix_lo;
  logic is_div, neg_quo, neg_rem;
  logic [WIDTH-1:0] hi_q, lo_q;

  muldiv_ctrl #(.STEPS(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .load_o  (load_en),
    .step_o  (step_en),
    .fix_o   (fix_en),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  muldiv_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .step_en   (step_en),
    .op_i      (op_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .raw_hi_o  (raw_hi),
    .raw_lo_o  (raw_lo),
    .is_div_o  (is_div),
    .neg_quo_o (neg_quo),
    .neg_rem_o (neg_rem)
  );

  muldiv_signfix #(.WIDTH(WIDTH)) u_fix (
    .is_div_i  (is_div),
    .neg_quo_i (neg_quo),
    .neg_rem_i (neg_rem),
    .raw_hi_i  (raw_hi),
    .raw_lo_i  (raw_lo),
    .hi_o      (fix_hi),
    .lo_o      (fix_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (fix_en) begin
      hi_q <= fix_hi;
      lo_q <= fix_lo;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/muldiv_seq_chk.sv
module muldiv_seq_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_i,
  input logic         busy_o,
  input logic         done_o,
  input logic [W-1:0] hi_o,
  input logic [W-1:0] lo_o
);
  localparam int LW = $clog2(W + 2) + 1;

  logic [LW-1:0] busy_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_len <= '0;
    else if (busy_o) busy_len <= busy_len + 1'b1;
    else             busy_len <= '0;
  end

  p_busy_on_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  p_busy_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (busy_len == LW'(W + 1)));

  p_busy_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (busy_len <= LW'(W)));

  p_done_after_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && busy_o) |=> (busy_o || done_o));

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(hi_o) && $stable(lo_o)));
endmodule

bind muldiv_seq muldiv_seq_chk #(.W(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .hi_o    (hi_o),
  .lo_o    (lo_o)
);

// File: tb/muldiv_seq_tb.sv
module muldiv_seq_tb;
  localparam int W = 32;

  logic clk, rst_n, start;
  logic [1:0] op;
  logic [W-1:0] a, b;
  logic busy, done;
  logic [W-1:0] hi, lo;

  int checks = 0;
  int errors = 0;

  muldiv_seq #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op),
    .a_i(a), .b_i(b), .busy_o(busy), .done_o(done), .hi_o(hi), .lo_o(lo)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference
  function automatic logic [63:0] ref_op(logic [1:0] o, logic [31:0] x, logic [31:0] y);
    longint sx, sy, sp, sq, sr;
    logic [63:0] r;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    case (o)
      2'b00: r = {32'b0, x} * {32'b0, y};
      2'b01: begin sp = sx * sy; r = sp; end
      2'b10: r = (y == 0) ? {x, 32'hFFFF_FFFF} : {x % y, x / y};
      default: begin
        if (y == 0) r = {x, (x[31] ? 32'h0000_0001 : 32'hFFFF_FFFF)};
        else begin
          sq = sx / sy;
          sr = sx % sy;
          r = {sr[31:0], sq[31:0]};
        end
      end
    endcase
    return r;
  endfunction

  function automatic string tag_for(logic [1:0] o, logic [31:0] y);
    if (o[1]) return (y == 0) ? "R7" : (o[0] ? "R6" : "R5");
    return o[0] ? "R4" : "R3";
  endfunction

  logic m_busy, m_done;
  logic [W-1:0] m_hi, m_lo;
  logic [63:0] m_pend;
  int m_cnt;
  string m_tag = "R1";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_hi = '0; m_lo = '0; m_cnt = 0;
    end else begin
      m_done = 1'b0;
      if (m_busy) begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_busy = 1'b0;
          m_done = 1'b1;
          {m_hi, m_lo} = m_pend;
        end
      end else if (start) begin
        m_busy = 1'b1;
        m_cnt  = W + 1;
        m_pend = ref_op(op, a, b);
        m_tag  = tag_for(op, b);
      end
    end
  end

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    string rt;
    rt = !rst_n ? "R1" : "R2";
    check(rt, "busy", 64'(busy), 64'(m_busy));
    check(rt, "done", 64'(done), 64'(m_done));
    rt = !rst_n ? "R1" : ((m_busy || m_done) ? m_tag : "R9");
    check(rt, "hi", 64'(hi), 64'(m_hi));
    check(rt, "lo", 64'(lo), 64'(m_lo));
  end

  task automatic do_op(logic [1:0] o, logic [31:0] x, logic [31:0] y, int poke_at, int gap);
    logic [63:0] exp;
    exp = ref_op(o, x, y);
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y;
    @(negedge clk);
    start = 1'b0;
    if (poke_at > 0) begin
      repeat (poke_at - 1) @(negedge clk);
      start = 1'b1; op = ~o; a = ~x; b = y + 32'd3;
      @(negedge clk);
      start = 1'b0;
    end
    while (m_busy) @(negedge clk);
    // R8: a poked run still produces its own result
    check((poke_at > 0) ? "R8" : tag_for(o, y), "result", {hi, lo}, exp);
    check("R2", "done pulse", 64'(done), 64'd1);
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; op = 2'b00; a = '0; b = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "idle after reset", {busy, done, hi, lo}, 64'd0);

    do_op(2'b00, 32'd0, 32'd0, 0, 1);
    do_op(2'b00, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0);
    do_op(2'b00, 32'h1234_5678, 32'h9ABC_DEF0, 0, 2);
    do_op(2'b01, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1);
    do_op(2'b01, 32'h8000_0000, 32'h8000_0000, 0, 1);
    do_op(2'b01, 32'h8000_0000, 32'd1, 0, 1);
    do_op(2'b01, 32'hFFFF_FFFD, 32'd5, 0, 1);
    do_op(2'b10, 32'd100, 32'd7, 0, 1);
    do_op(2'b10, 32'hFFFF_FFFF, 32'd1, 0, 1);
    do_op(2'b10, 32'd5, 32'd10, 0, 1);
    do_op(2'b10, 32'd0, 32'd3, 0, 1);
    do_op(2'b11, 32'hFFFF_FFF9, 32'd2, 0, 1);
    do_op(2'b11, 32'd7, 32'hFFFF_FFFE, 0, 1);
    do_op(2'b11, 32'hFFFF_FFF9, 32'hFFFF_FFFE, 0, 1);
    do_op(2'b11, 32'h8000_0000, 32'hFFFF_FFFF, 0, 1);
    do_op(2'b11, 32'h8000_0000, 32'd1, 0, 1);
    // R7: zero divisor
    do_op(2'b10, 32'd1234, 32'd0, 0, 1);
    do_op(2'b11, 32'd5, 32'd0, 0, 1);
    do_op(2'b11, 32'hFFFF_FFFB, 32'd0, 0, 1);
    do_op(2'b11, 32'h8000_0000, 32'd0, 0, 1);
    // R8: start while busy
    do_op(2'b00, 32'd40000, 32'd70000, 5, 1);
    do_op(2'b11, 32'hFFFF_0000, 32'd77, 20, 1);
    do_op(2'b01, 32'd9, 32'hFFFF_FFF0, 31, 1);
    // R9: results hold across an idle stretch
    repeat (8) @(negedge clk);
    check("R9", "hold", {hi, lo}, ref_op(2'b01, 32'd9, 32'hFFFF_FFF0));

    for (int i = 0; i < 150; i++) begin
      logic [31:0] rx, ry;
      rx = $urandom;
      ry = $urandom;
      if (i % 3 == 0) ry = ry & 32'h0000_00FF;
      if (i % 17 == 0) ry = '0;
      do_op(2'($urandom), rx, ry, (i % 5 == 0) ? int'($urandom_range(1, 30)) : 0, i % 3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule